// File: doc/BRIEF.md
# Segment Selector Load and Check Unit

This block holds the six segment registers of a processor core (ES, CS, SS, DS, FS, GS). Each entry has a visible 16-bit selector and a hidden 64-bit descriptor cache. A load request carries a segment code and a 32-bit source value. The block takes the low half of the source as the selector, validates it, fetches the matching descriptor through a request/valid read port, and commits selector and descriptor together. Reads return the selected register zero-extended to 32 bits, together with its cached descriptor.

Selectors 0x0000 to 0x0003 are null. A null selector may be parked in a data segment. Any later memory reference through that segment is refused with a general-protection fault, and no access is issued. Loading a null selector into SS or CS is refused. The block also keeps a one-instruction interrupt shadow after a successful SS load. This shadow does not chain behind a window that is already open.

The controller is a four-state machine:
- ST_IDLE: waits for a request and latches it.
- ST_CHECK: handles null selectors, reserved segment codes and the table limit check.
- ST_FETCH: raises the descriptor request for one cycle.
- ST_WAIT: waits for the returned descriptor.

The transitions are:
- ST_IDLE to ST_CHECK when a request arrives.
- ST_CHECK back to ST_IDLE when the load finishes or faults there.
- ST_CHECK to ST_FETCH when a fetch is needed.
- ST_FETCH to ST_WAIT unconditionally.
- ST_WAIT back to ST_IDLE when the descriptor returns.

Top module: `seg_load_unit`

## Requirements
- R1: A null selector (0x0000 to 0x0003) loaded into ES (code 0), DS (3), FS (4) or GS (5) completes without a fault and without a descriptor fetch. The entry then holds that selector, a zero descriptor cache and the null mark.
- R2: A null selector loaded into CS (code 1) or SS (code 2) faults with error code 0x0000, as does any load naming code 6 or 7. The entry is left unchanged.
- R3: With mem_req high, a segment marked null (or a code of 6 or 7) gives mem_gp=1 and mem_issue=0. A non-null segment gives mem_issue=1 and mem_gp=0.
- R4: For a non-null selector, exactly one descriptor read is issued. Its address is the local table base when selector bit 2 is set, or the global table base when it is clear, plus the selector index (bits 15:3) times 8.
- R5: The visible selector and the descriptor cache of the target entry both change in the cycle in which ld_done is high, and not earlier.
- R6: If the index times 8 plus 7 exceeds the chosen table limit, the load faults with error code equal to the selector with bits 1:0 cleared. No read is issued and the entry is unchanged.
- R7: If the returned descriptor has bit 47 (present) clear, the load faults with error code equal to the selector with bits 1:0 cleared, and the entry is unchanged.
- R8: Only bits 15:0 of ld_src form the selector; bits 31:16 have no effect.
- R9: rd_data equals the selector of segment rd_seg with bits 31:16 zero. rd_desc equals that segment's descriptor cache.
- R10: A successful SS load sets int_inhibit in the cycle after ld_done. The next retire event clears it. A retire event is an instr_retire pulse or a finished load.
- R11: If int_inhibit is already set (for example by a retire with instr_sti high) when an SS load finishes, the load clears it and does not set it again.
- R12: After reset, all six entries hold selector 0, a zero cache and the null mark. int_inhibit and ld_busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load request, taken when ld_busy is low |
| ld_seg | input | 3 | Target segment code (ES=0, CS=1, SS=2, DS=3, FS=4, GS=5) |
| ld_src | input | 32 | Source general-register value |
| ld_busy | output | 1 | A load is in progress |
| ld_done | output | 1 | One-cycle pulse: load committed |
| ld_fault | output | 1 | One-cycle pulse: load refused (general protection) |
| ld_err_code | output | 16 | Error code, valid with ld_fault |
| gdt_base | input | 32 | Global descriptor table base address |
| gdt_limit | input | 16 | Global table limit in bytes |
| ldt_base | input | 32 | Local descriptor table base address |
| ldt_limit | input | 16 | Local table limit in bytes |
| desc_req | output | 1 | Descriptor read request (one cycle) |
| desc_addr | output | 32 | Descriptor read address |
| desc_rvalid | input | 1 | Descriptor data valid |
| desc_rdata | input | 64 | Returned descriptor |
| rd_seg | input | 3 | Segment to read |
| rd_data | output | 32 | Zero-extended selector of rd_seg |
| rd_desc | output | 64 | Descriptor cache of rd_seg |
| mem_req | input | 1 | Memory reference request |
| mem_seg | input | 3 | Segment used by the reference |
| mem_issue | output | 1 | Reference may proceed |
| mem_gp | output | 1 | Reference refused: null segment |
| instr_retire | input | 1 | Another instruction retires |
| instr_sti | input | 1 | Retiring instruction opens an interrupt-delay window |
| int_inhibit | output | 1 | Interrupt recognition blocked |

## Verification
The hardest condition to reach is the non-chaining shadow. The SS load must finish while a window opened by an earlier retire is still active. The stimulus gets there by pulsing instr_retire with instr_sti and issuing no other retire before the SS load finishes, so the load is the retire that closes that window. A second hard case is the cycle just before commit. The descriptor responder holds back its answer for two cycles, and the monitor checks on every cycle of the wait that the visible selector still shows its old value.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NUM_SEGS   = 6;
    localparam int IDX_W      = 3;
    localparam int SEL_W      = 16;
    localparam int DESC_W     = 64;
    localparam int ADDR_W     = 32;
    localparam int GPR_W      = 32;
    localparam int PRESENT_BIT = 47;

    localparam logic [IDX_W-1:0] SEG_ES = 3'd0;
    localparam logic [IDX_W-1:0] SEG_CS = 3'd1;
    localparam logic [IDX_W-1:0] SEG_SS = 3'd2;
    localparam logic [IDX_W-1:0] SEG_DS = 3'd3;
    localparam logic [IDX_W-1:0] SEG_FS = 3'd4;
    localparam logic [IDX_W-1:0] SEG_GS = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2,
        ST_WAIT  = 2'd3
    } ld_state_e;
endpackage

// File: rtl/seg_ld_fsm.sv
module seg_ld_fsm
    import seg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_valid,
    input  logic [IDX_W-1:0]    ld_seg,
    input  logic [GPR_W-1:0]    ld_src,
    input  logic [ADDR_W-1:0]   gdt_base,
    input  logic [SEL_W-1:0]    gdt_limit,
    input  logic [ADDR_W-1:0]   ldt_base,
    input  logic [SEL_W-1:0]    ldt_limit,
    input  logic                desc_rvalid,
    input  logic [DESC_W-1:0]   desc_rdata,
    output logic                busy,
    output logic                desc_req,
    output logic [ADDR_W-1:0]   desc_addr,
    output logic                wr_en,
    output logic                wr_null,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [SEL_W-1:0]    wr_sel,
    output logic [DESC_W-1:0]   wr_desc,
    output logic                done,
    output logic                fault,
    output logic [SEL_W-1:0]    err_code
);
    ld_state_e           st, st_nxt;
    logic [IDX_W-1:0]    req_seg;
    logic [SEL_W-1:0]    req_sel;
    logic                fin_ok, fin_bad;
    logic [SEL_W-1:0]    bad_code;

    logic                sel_null, seg_bad, use_local, over_limit;
    logic [SEL_W-1:0]    lim;
    logic [SEL_W-1:0]    code_rpl_clr;

    assign sel_null     = (req_sel[SEL_W-1:2] == '0);
    assign seg_bad      = (32'(req_seg) >= NUM_SEGS);
    assign use_local    = req_sel[2];
    assign lim          = use_local ? ldt_limit : gdt_limit;
    assign over_limit   = ({req_sel[SEL_W-1:3], 3'b111} > lim);
    assign code_rpl_clr = {req_sel[SEL_W-1:2], 2'b00};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // next state and commit decision
    always_comb begin
        st_nxt   = st;
        wr_en    = 1'b0;
        wr_null  = 1'b0;
        wr_desc  = '0;
        fin_ok   = 1'b0;
        fin_bad  = 1'b0;
        bad_code = '0;
        unique case (st)
            ST_IDLE: if (ld_valid) st_nxt = ST_CHECK;
            ST_CHECK: begin
                st_nxt = ST_IDLE;
                if (seg_bad) begin
                    fin_bad = 1'b1;
                end else if (sel_null) begin
                    if (req_seg == SEG_SS || req_seg == SEG_CS) begin
                        fin_bad = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_null = 1'b1;
                        fin_ok  = 1'b1;
                    end
                end else if (over_limit) begin
                    fin_bad  = 1'b1;
                    bad_code = code_rpl_clr;
                end else begin
                    st_nxt = ST_FETCH;
                end
            end
            ST_FETCH: st_nxt = ST_WAIT;
            ST_WAIT: if (desc_rvalid) begin
                st_nxt = ST_IDLE;
                if (desc_rdata[PRESENT_BIT]) begin
                    wr_en   = 1'b1;
                    wr_desc = desc_rdata;
                    fin_ok  = 1'b1;
                end else begin
                    fin_bad  = 1'b1;
                    bad_code = code_rpl_clr;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // registered outputs and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seg  <= '0;
            req_sel  <= '0;
            done     <= 1'b0;
            fault    <= 1'b0;
            err_code <= '0;
        end else begin
            done  <= fin_ok;
            fault <= fin_bad;
            if (fin_bad) err_code <= bad_code;
            if (st == ST_IDLE && ld_valid) begin
                req_seg <= ld_seg;
                req_sel <= ld_src[SEL_W-1:0];
            end
        end
    end

    assign busy      = (st != ST_IDLE);
    assign desc_req  = (st == ST_FETCH);
    assign desc_addr = (use_local ? ldt_base : gdt_base)
                     + ADDR_W'({req_sel[SEL_W-1:3], 3'b000});
    assign wr_idx    = req_seg;
    assign wr_sel    = req_sel;

    // R4
    fetch_nonnull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |-> !sel_null && !over_limit);
    // R6
    err_rpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> err_code[1:0] == 2'b00);
    // R5
    one_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_null,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DESC_W-1:0]       wr_desc,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [SEL_W-1:0]        rd_sel,
    output logic [DESC_W-1:0]       rd_desc,
    output logic [NUM_SEGS-1:0]     null_vec
);
    logic [NUM_SEGS-1:0][SEL_W-1:0]  sel_all;
    logic [NUM_SEGS-1:0][DESC_W-1:0] desc_all;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
        logic [SEL_W-1:0]  sel_q;
        logic [DESC_W-1:0] desc_q;
        logic              null_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q  <= '0;
                desc_q <= '0;
                null_q <= 1'b1;
            end else if (wr_en && 32'(wr_idx) == g) begin
                sel_q  <= wr_sel;
                desc_q <= wr_desc;
                null_q <= wr_null;
            end
        end
        assign sel_all[g]  = sel_q;
        assign desc_all[g] = desc_q;
        assign null_vec[g] = null_q;
    end

    assign rd_sel  = (32'(rd_idx) < NUM_SEGS) ? sel_all[rd_idx]  : '0;
    assign rd_desc = (32'(rd_idx) < NUM_SEGS) ? desc_all[rd_idx] : '0;
endmodule

// File: rtl/seg_irq_shadow.sv
module seg_irq_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic retire,
    input  logic opens,
    output logic inhibit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      inhibit <= 1'b0;
        else if (retire) inhibit <= inhibit ? 1'b0 : opens;
    end

    // R10
    shadow_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit && retire |=> !inhibit);
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_valid,
    input  logic [2:0]   ld_seg,
    input  logic [31:0]  ld_src,
    output logic         ld_busy,
    output logic         ld_done,
    output logic         ld_fault,
    output logic [15:0]  ld_err_code,
    input  logic [31:0]  gdt_base,
    input  logic [15:0]  gdt_limit,
    input  logic [31:0]  ldt_base,
    input  logic [15:0]  ldt_limit,
    output logic         desc_req,
    output logic [31:0]  desc_addr,
    input  logic         desc_rvalid,
    input  logic [63:0]  desc_rdata,
    input  logic [2:0]   rd_seg,
    output logic [31:0]  rd_data,
    output logic [63:0]  rd_desc,
    input  logic         mem_req,
    input  logic [2:0]   mem_seg,
    output logic         mem_issue,
    output logic         mem_gp,
    input  logic         instr_retire,
    input  logic         instr_sti,
    output logic         int_inhibit
);
    logic                wr_en, wr_null;
    logic [IDX_W-1:0]    wr_idx;
    logic [SEL_W-1:0]    wr_sel, rd_sel;
    logic [DESC_W-1:0]   wr_desc;
    logic [NUM_SEGS-1:0] null_vec;
    logic [IDX_W-1:0]    fin_seg_q;
    logic                retire_any, opens, ref_null;

    seg_ld_fsm i_fsm (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_src(ld_src),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .desc_rvalid(desc_rvalid), .desc_rdata(desc_rdata),
        .busy(ld_busy), .desc_req(desc_req), .desc_addr(desc_addr),
        .wr_en(wr_en), .wr_null(wr_null), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_desc(wr_desc),
        .done(ld_done), .fault(ld_fault), .err_code(ld_err_code)
    );

    seg_regfile i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_null(wr_null), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_desc(wr_desc),
        .rd_idx(rd_seg), .rd_sel(rd_sel), .rd_desc(rd_desc),
        .null_vec(null_vec)
    );

    // segment of the finishing load, captured with the commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fin_seg_q <= '0;
        else if (wr_en)  fin_seg_q <= wr_idx;
    end

    assign retire_any = instr_retire | ld_done | ld_fault;
    assign opens      = (instr_retire & instr_sti) | (ld_done & (fin_seg_q == SEG_SS));

    seg_irq_shadow i_shadow (
        .clk(clk), .rst_n(rst_n),
        .retire(retire_any), .opens(opens), .inhibit(int_inhibit)
    );

    assign rd_data   = {{(GPR_W-SEL_W){1'b0}}, rd_sel};
    assign ref_null  = (32'(mem_seg) < NUM_SEGS) ? null_vec[mem_seg] : 1'b1;
    assign mem_gp    = mem_req & ref_null;
    assign mem_issue = mem_req & ~ref_null;

    // R2
    ss_never_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done && fin_seg_q == SEG_SS |-> !null_vec[SEG_SS]);
    // R10
    ss_shadow_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done && fin_seg_q == SEG_SS && !int_inhibit |=> int_inhibit);
    // R3
    null_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && 32'(mem_seg) < NUM_SEGS && null_vec[mem_seg] |-> mem_gp && !mem_issue);
endmodule

// File: tb/test_seg_load_unit.sv
module test_seg_load_unit;
    localparam time CLK_PERIOD = 10;
    localparam logic [31:0] GBASE = 32'h0001_0000;
    localparam logic [31:0] LBASE = 32'h0002_0400;
    localparam logic [15:0] GLIM  = 16'h00FF;
    localparam logic [15:0] LLIM  = 16'h003F;

    typedef struct {
        logic [2:0]  seg;
        logic [15:0] sel;
        logic        fault;
        logic [15:0] code;
        logic [63:0] desc;
        logic        nul;
        int          fetches;
        logic [31:0] addr;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic ld_valid = 0; logic [2:0] ld_seg = 0; logic [31:0] ld_src = 0;
    logic ld_busy, ld_done, ld_fault; logic [15:0] ld_err_code;
    logic desc_req; logic [31:0] desc_addr;
    logic desc_rvalid = 0; logic [63:0] desc_rdata = 0;
    logic [2:0] rd_seg = 0; logic [31:0] rd_data; logic [63:0] rd_desc;
    logic mem_req = 0; logic [2:0] mem_seg = 0; logic mem_issue, mem_gp;
    logic instr_retire = 0, instr_sti = 0, int_inhibit;

    int checks = 0, errors = 0, fin_cnt = 0, fetch_seen = 0, resp_cnt = 0;
    logic [31:0] resp_addr = 0;
    logic pend = 0, finished = 0;
    exp_t sbq[$];
    logic [15:0] m_sel [6];
    logic [63:0] m_desc [6];
    logic        m_null [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_load_unit i_seg_load_unit (
        .clk, .rst_n, .ld_valid, .ld_seg, .ld_src, .ld_busy, .ld_done, .ld_fault,
        .ld_err_code, .gdt_base(GBASE), .gdt_limit(GLIM), .ldt_base(LBASE),
        .ldt_limit(LLIM), .desc_req, .desc_addr, .desc_rvalid, .desc_rdata,
        .rd_seg, .rd_data, .rd_desc, .mem_req, .mem_seg, .mem_issue, .mem_gp,
        .instr_retire, .instr_sti, .int_inhibit
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] desc_of(input logic [31:0] a);
        logic [7:0] attr = (a == GBASE + 32'd40) ? 8'h12 : 8'h92;
        return {16'h00CF, attr, 8'h00, a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    // driver: computes the expected result and pushes it, then drives the request
    task automatic do_load(input logic [2:0] seg, input logic [31:0] src);
        exp_t e;
        logic [15:0] s = src[15:0];
        logic [15:0] lim = s[2] ? LLIM : GLIM;
        int start = fin_cnt;
        e.seg = seg; e.sel = s; e.fault = 0; e.code = 0; e.desc = 0;
        e.nul = 0; e.fetches = 0; e.addr = 0;
        if (seg > 3'd5) e.fault = 1;
        else if (s < 16'd4) begin
            if (seg == 3'd1 || seg == 3'd2) e.fault = 1;
            else e.nul = 1;
        end else if ({s[15:3], 3'b111} > lim) begin
            e.fault = 1; e.code = {s[15:2], 2'b00};
        end else begin
            e.fetches = 1;
            e.addr = (s[2] ? LBASE : GBASE) + {16'h0, s[15:3], 3'b000};
            e.desc = desc_of(e.addr);
            if (!e.desc[47]) begin e.fault = 1; e.code = {s[15:2], 2'b00}; e.desc = 0; end
        end
        sbq.push_back(e);
        fetch_seen = 0;
        rd_seg = (seg > 3'd5) ? 3'd0 : seg;
        pend = 1;
        ld_valid = 1; ld_seg = seg; ld_src = src;
        @(negedge clk); #1;
        ld_valid = 0;
        while (fin_cnt == start) begin @(negedge clk); #1; end
        pend = 0;
    endtask

    // monitor and descriptor responder in one process
    always @(negedge clk) begin
        exp_t e;
        desc_rvalid = 0;
        if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin desc_rvalid = 1; desc_rdata = desc_of(resp_addr); end
        end
        if (desc_req) begin
            fetch_seen++;
            resp_addr = desc_addr; resp_cnt = 2;
            if (sbq.size() > 0)
                chk(desc_addr == sbq[0].addr, "R4 fetch address", desc_addr, sbq[0].addr);
        end
        if (rst_n && (ld_done || ld_fault)) begin
            if (sbq.size() == 0) chk(0, "R5 unexpected finish", 1, 0);
            else begin
                e = sbq.pop_front();
                chk(ld_fault == e.fault, "R2/R6/R7 fault flag", ld_fault, e.fault);
                chk(fetch_seen == e.fetches, "R4 fetch count", fetch_seen, e.fetches);
                if (e.fault) chk(ld_err_code == e.code, "R6/R7 error code", ld_err_code, e.code);
                if (!e.fault) begin
                    m_sel[e.seg] = e.sel; m_desc[e.seg] = e.desc; m_null[e.seg] = e.nul;
                end
                if (e.seg <= 3'd5) begin
                    chk(rd_data == {16'h0, m_sel[e.seg]}, "R5/R9 selector at finish", rd_data, {16'h0, m_sel[e.seg]});
                    chk(rd_desc == m_desc[e.seg], "R5 descriptor at finish", rd_desc, m_desc[e.seg]);
                end
            end
            fin_cnt++;
        end else if (pend && ld_busy) begin
            chk(rd_data == {16'h0, m_sel[rd_seg]}, "R5 no early update", rd_data, {16'h0, m_sel[rd_seg]});
        end
    end

    task automatic mem_chk(input logic [2:0] seg, input logic gp);
        mem_req = 1; mem_seg = seg; #1;
        chk(mem_gp == gp && mem_issue == !gp, "R3 memory reference", {mem_gp, mem_issue}, {gp, !gp});
        mem_req = 0;
    endtask

    task automatic retire_pulse(input logic sti);
        instr_retire = 1; instr_sti = sti;
        @(negedge clk); #1;
        instr_retire = 0; instr_sti = 0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 6; i++) begin m_sel[i] = 0; m_desc[i] = 0; m_null[i] = 1; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R12 reset state
        chk(!int_inhibit && !ld_busy, "R12 reset flags", {int_inhibit, ld_busy}, 0);
        for (int i = 0; i < 6; i++) begin
            rd_seg = 3'(i); #1;
            chk(rd_data == 0 && rd_desc == 0, "R12 reset entry", rd_data, 0);
            mem_chk(3'(i), 1'b1);
        end
        // R8 upper bits ignored, R4 global table, R9 zero-extended read
        do_load(3'd3, 32'hDEAD_0013);
        chk(rd_data == 32'h0000_0013, "R8 low half only", rd_data, 32'h13);
        mem_chk(3'd3, 1'b0);
        // R4 local table
        do_load(3'd0, 32'h0000_001C);
        mem_chk(3'd0, 1'b0);
        // R1 null into DS, then R3 reference faults
        do_load(3'd3, 32'hFFFF_0002);
        mem_chk(3'd3, 1'b1);
        mem_chk(3'd0, 1'b0);
        // R2 null into SS and CS, reserved code
        do_load(3'd2, 32'h0000_0003);
        do_load(3'd1, 32'h0000_0000);
        do_load(3'd6, 32'h0000_0010);
        mem_chk(3'd6, 1'b1);
        // R6 beyond local limit
        do_load(3'd4, 32'h0000_0104);
        mem_chk(3'd4, 1'b1);
        // R7 not-present descriptor
        do_load(3'd5, 32'h0000_0028);
        mem_chk(3'd5, 1'b1);
        // R10 SS load opens shadow, next retire closes it
        chk(!int_inhibit, "R10 idle before SS load", int_inhibit, 0);
        do_load(3'd2, 32'h0000_0010);
        @(negedge clk); #1;
        chk(int_inhibit == 1, "R10 shadow after SS load", int_inhibit, 1);
        retire_pulse(1'b0);
        chk(int_inhibit == 0, "R10 shadow cleared on retire", int_inhibit, 0);
        mem_chk(3'd2, 1'b0);
        // R11 window already open: SS load does not extend it
        retire_pulse(1'b1);
        chk(int_inhibit == 1, "R11 window opened", int_inhibit, 1);
        do_load(3'd2, 32'h0000_0018);
        @(negedge clk); #1;
        chk(int_inhibit == 0, "R11 no chaining", int_inhibit, 0);
        chk(sbq.size() == 0, "R5 scoreboard drained", sbq.size(), 0);
        finish_run();
    end
endmodule